// File: doc/BRIEF.md
# Multithreaded Thread-Select and Fetch-PC Unit

This unit sits at the front of a single-issue pipeline that is shared by several hardware threads. Every cycle it decides which thread supplies the next instruction, presents that thread's program counter to the fetch stage, and keeps one private program counter per thread. The fetch stage answers with an advance strobe when it takes the offered address. Only then does the issuing thread's counter step forward.

A mode input picks one of two scheduling policies.

- **Interleaved mode.** The offer rotates round-robin on every clock. Any thread with a stall flag raised is passed over, and changing threads costs no cycle.
- **Switch-on-long-stall mode.** One thread keeps the pipeline until it reports a long-latency stall. The unit then moves to the next ready thread in rotation order and raises a one-cycle flush so that the pipeline is emptied. It then holds the offer off for a fixed refill interval.

Per-thread redirect inputs load branch targets into the counters.

Top module: `mtf_thread_fetch`

## Requirements
- R1: After reset every thread's PC equals the reset vector, thread 0 is the running/next thread, and flush is low.
- R2: In interleaved mode (mode=0) the offered thread is the first thread, searching upward with wrap-around from the rotation pointer, whose short and long stall flags are both low. The offer is valid in the same cycle as the stall inputs, with no extra cycle.
- R3: In interleaved mode, each taken offer (valid and advance both high) moves the rotation pointer to the thread after the issued one. A different thread is therefore offered on the next cycle whenever another thread is ready.
- R4: A thread with either stall flag set is never offered with valid high.
- R5: When every thread is stalled, valid is low and no PC changes unless it is redirected.
- R6: A thread's PC increases by 4 only in the cycle after that thread's offer is taken. An advance strobe while valid is low changes nothing.
- R7: A redirect for a thread loads its target into that thread's PC on the next clock. The redirect wins over a simultaneous increment.
- R8: In switch mode (mode=1) the running thread stays selected. A short stall on it only lowers valid and never causes a switch.
- R9: In switch mode, a long stall on the running thread moves the selection to the next thread after it, in rotation order, whose stall flags are both low. Flush is then high for exactly the following cycle.
- R10: Valid stays low for REFILL cycles, counting from the flush cycle. No further switch happens during that interval.
- R11: In switch mode, a long stall when no other thread is ready causes no switch and no flush, and valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = interleave every cycle, 1 = switch on long stall |
| stall_short | input | NTHR | Per-thread short stall flags |
| stall_long | input | NTHR | Per-thread long-latency stall flags |
| redir_vld | input | NTHR | Per-thread redirect strobe |
| redir_pc | input | NTHR*PCW | Per-thread redirect targets, thread t in bits [t*PCW +: PCW] |
| adv | input | 1 | Fetch stage takes the current offer |
| sel_tid | output | $clog2(NTHR) | Offered / running thread |
| fetch_pc | output | PCW | PC of the offered thread |
| fetch_vld | output | 1 | Offer is valid |
| flush | output | 1 | One-cycle pipeline flush request |

## Verification
Two events can land on the same clock. A redirect can arrive for the very thread whose offer is being taken, so the increment and the load compete for one counter. A long stall can also hit a thread that has just been switched in, while the refill interval is still running. The bench forces both cases directly: it redirects the offered thread while the advance strobe is high, and it raises a long stall on the new thread during refill. Random traffic then keeps producing both collisions. A reference model in the bench judges every cycle and expects the redirect target rather than PC+4, and no second flush until the refill has ended.

// File: rtl/mtf_pkg.sv
package mtf_pkg;
  typedef enum logic {
    SCHED_INTERLEAVE = 1'b0,
    SCHED_ON_LONG    = 1'b1
  } sched_e;
endpackage

// File: rtl/mtf_rr_pick.sv
module mtf_rr_pick #(
  parameter int N  = 4,
  parameter int TW = $clog2(N)
) (
  input  logic [N-1:0]  ready,
  input  logic [TW-1:0] start,
  output logic          found,
  output logic [TW-1:0] idx
);
  // walk backwards so the candidate closest to start wins
  always_comb begin
    found = 1'b0;
    idx   = start;
    for (int k = N - 1; k >= 0; k--) begin
      int j;
      j = (int'(start) + k) % N;
      if (ready[j]) begin
        found = 1'b1;
        idx   = TW'(j);
      end
    end
  end
endmodule

// File: rtl/mtf_pc_bank.sv
module mtf_pc_bank #(
  parameter int             N         = 4,
  parameter int             PCW       = 32,
  parameter logic [PCW-1:0] RESET_VEC = '0,
  parameter int             TW        = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     redir_vld,
  input  logic [N*PCW-1:0] redir_pc,
  input  logic             issue,
  input  logic [TW-1:0]    issue_tid,
  output logic [N*PCW-1:0] pcs
);
  function automatic logic [PCW-1:0] seq_step(input logic [PCW-1:0] pc);
    return pc + PCW'(4);
  endfunction

  for (genvar t = 0; t < N; t++) begin : g_thr
    logic [PCW-1:0] pc_q;
    logic           bump;
    assign bump = issue && (issue_tid == TW'(t));
    always_ff @(posedge clk) begin
      if (!rst_n)            pc_q <= RESET_VEC;
      else if (redir_vld[t]) pc_q <= redir_pc[t*PCW +: PCW];
      else if (bump)         pc_q <= seq_step(pc_q);
    end
    assign pcs[t*PCW +: PCW] = pc_q;
  end
endmodule

// File: rtl/mtf_refill_ctl.sv
module mtf_refill_ctl #(
  parameter int REFILL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic switch_evt,
  output logic flush,
  output logic busy
);
  localparam int CW = $clog2(REFILL + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flush <= 1'b0;
    end else begin
      flush <= switch_evt;
      if (switch_evt)       cnt_q <= CW'(REFILL);
      else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/mtf_thread_fetch.sv
module mtf_thread_fetch #(
  parameter int             NTHR      = 4,
  parameter int             PCW       = 32,
  parameter logic [PCW-1:0] RESET_VEC = PCW'('h1000),
  parameter int             REFILL    = 3,
  localparam int            TW        = $clog2(NTHR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic [NTHR-1:0]   stall_short,
  input  logic [NTHR-1:0]   stall_long,
  input  logic [NTHR-1:0]   redir_vld,
  input  logic [NTHR*PCW-1:0] redir_pc,
  input  logic              adv,
  output logic [TW-1:0]     sel_tid,
  output logic [PCW-1:0]    fetch_pc,
  output logic              fetch_vld,
  output logic              flush
);
  import mtf_pkg::*;

  function automatic logic [TW-1:0] next_tid(input logic [TW-1:0] t);
    return (int'(t) == NTHR - 1) ? '0 : t + TW'(1);
  endfunction

  sched_e             sched;
  logic [NTHR-1:0]    ready;
  logic [TW-1:0]      cur_q;
  logic               fnd_il, fnd_sw;
  logic [TW-1:0]      pick_il, pick_sw;
  logic               offer_raw;
  logic               busy;
  logic               issue;
  logic               switch_evt;
  logic [NTHR*PCW-1:0] pcs;

  assign sched = sched_e'(mode);
  assign ready = ~(stall_short | stall_long);

  // interleave candidate: search from the rotation pointer itself
  mtf_rr_pick #(.N(NTHR), .TW(TW)) u_pick_il (
    .ready (ready),
    .start (cur_q),
    .found (fnd_il),
    .idx   (pick_il)
  );

  // switch candidate: search from the thread after the running one
  mtf_rr_pick #(.N(NTHR), .TW(TW)) u_pick_sw (
    .ready (ready),
    .start (next_tid(cur_q)),
    .found (fnd_sw),
    .idx   (pick_sw)
  );

  always_comb begin
    if (sched == SCHED_INTERLEAVE) begin
      sel_tid   = fnd_il ? pick_il : cur_q;
      offer_raw = fnd_il;
    end else begin
      sel_tid   = cur_q;
      offer_raw = ready[cur_q];
    end
  end

  assign fetch_vld  = offer_raw && !busy;
  assign issue      = fetch_vld && adv;
  assign switch_evt = (sched == SCHED_ON_LONG) && !busy && stall_long[cur_q] && fnd_sw;

  always_ff @(posedge clk) begin
    if (!rst_n)                                    cur_q <= '0;
    else if (switch_evt)                           cur_q <= pick_sw;
    else if (sched == SCHED_INTERLEAVE && issue)   cur_q <= next_tid(sel_tid);
  end

  mtf_refill_ctl #(.REFILL(REFILL)) u_refill (
    .clk        (clk),
    .rst_n      (rst_n),
    .switch_evt (switch_evt),
    .flush      (flush),
    .busy       (busy)
  );

  mtf_pc_bank #(.N(NTHR), .PCW(PCW), .RESET_VEC(RESET_VEC), .TW(TW)) u_pcs (
    .clk       (clk),
    .rst_n     (rst_n),
    .redir_vld (redir_vld),
    .redir_pc  (redir_pc),
    .issue     (issue),
    .issue_tid (sel_tid),
    .pcs       (pcs)
  );

  assign fetch_pc = pcs[sel_tid*PCW +: PCW];
endmodule

// File: rtl/mtf_thread_fetch_chk.sv
module mtf_thread_fetch_chk #(
  parameter int NTHR = 4,
  parameter int PCW  = 32,
  parameter int TW   = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mode,
  input logic [NTHR-1:0]     stall_short,
  input logic [NTHR-1:0]     stall_long,
  input logic [NTHR-1:0]     redir_vld,
  input logic [NTHR*PCW-1:0] redir_pc,
  input logic [TW-1:0]       sel_tid,
  input logic                fetch_vld,
  input logic                flush,
  input logic                switch_evt,
  input logic [NTHR*PCW-1:0] pcs
);
  // R4
  stalled_never_offered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld |-> !(stall_short[sel_tid] || stall_long[sel_tid]));

  // R5
  all_stalled_no_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&(stall_short | stall_long)) |-> !fetch_vld);

  // R6
  idle_pcs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_vld && redir_vld == '0) |=> $stable(pcs));

  // R7
  redirect_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld[0] |=> pcs[PCW-1:0] == $past(redir_pc[PCW-1:0]));

  // R9
  switch_flags_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_evt |=> flush);

  // R9
  flush_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  // R10
  flush_blocks_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !fetch_vld);

  // R8
  hold_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && $past(mode) && !flush) |-> sel_tid == $past(sel_tid));
endmodule

bind mtf_thread_fetch mtf_thread_fetch_chk #(.NTHR(NTHR), .PCW(PCW), .TW(TW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode),
  .stall_short (stall_short),
  .stall_long  (stall_long),
  .redir_vld   (redir_vld),
  .redir_pc    (redir_pc),
  .sel_tid     (sel_tid),
  .fetch_vld   (fetch_vld),
  .flush       (flush),
  .switch_evt  (switch_evt),
  .pcs         (pcs)
);

// File: tb/mtf_thread_fetch_bench.sv
`timescale 1ns/1ps
module mtf_thread_fetch_bench;
  localparam int          NT   = 4;
  localparam int          PW   = 32;
  localparam logic [31:0] RV   = 32'h0000_1000;
  localparam int          RF   = 3;
  localparam real         TCLK = 5.0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b0;
  logic [NT-1:0] ss = '0, sl = '0, rv = '0;
  logic [NT*PW-1:0] rp = '0;
  logic          adv = 1'b0;
  logic [1:0]    sel_tid;
  logic [31:0]   fetch_pc;
  logic          fetch_vld, flush;

  int checks = 0, errors = 0;

  logic [1:0]  m_cur;
  logic [31:0] m_pc [NT];
  int          m_rc;
  bit          m_fl;

  always #(TCLK/2) clk = ~clk;

  mtf_thread_fetch #(.NTHR(NT), .PCW(PW), .RESET_VEC(RV), .REFILL(RF)) u_mtf_thread_fetch (
    .clk(clk), .rst_n(rst_n), .mode(mode), .stall_short(ss), .stall_long(sl),
    .redir_vld(rv), .redir_pc(rp), .adv(adv), .sel_tid(sel_tid),
    .fetch_pc(fetch_pc), .fetch_vld(fetch_vld), .flush(flush));

  // first ready thread at or after 'from', wrapping; -1 if none
  function automatic int first_ready(logic [NT-1:0] ok, int from);
    for (int k = 0; k < NT; k++) begin
      int j = (from + k) % NT;
      if (ok[j]) return j;
    end
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cur = 0; m_rc = 0; m_fl = 0;
    for (int t = 0; t < NT; t++) m_pc[t] = RV;
  endtask

  // inputs already driven after a negedge; compare, then advance the model across one edge
  task automatic step(string tag);
    logic [NT-1:0] rdy;
    int f, g, e_sel;
    bit e_vld, issue, sw;
    #1;
    rdy = ~(ss | sl);
    if (!mode) begin
      f = first_ready(rdy, m_cur);
      e_sel = (f < 0) ? int'(m_cur) : f;
      e_vld = (f >= 0);
    end else begin
      e_sel = m_cur;
      e_vld = rdy[m_cur];
    end
    e_vld = e_vld && (m_rc == 0);
    chk(fetch_vld == e_vld, tag, "valid", fetch_vld, e_vld);
    chk(flush == m_fl, tag, "flush", flush, m_fl);
    if (e_vld) begin
      chk(int'(sel_tid) == e_sel, tag, "thread", sel_tid, e_sel);
      chk(fetch_pc == m_pc[e_sel], tag, "pc", fetch_pc, m_pc[e_sel]);
    end
    issue = e_vld && adv;
    g = first_ready(rdy, (int'(m_cur) + 1) % NT);
    sw = mode && (m_rc == 0) && sl[m_cur] && (g >= 0);
    @(posedge clk);
    for (int t = 0; t < NT; t++) begin
      if (rv[t]) m_pc[t] = rp[t*PW +: PW];
      else if (issue && t == e_sel) m_pc[t] = m_pc[t] + 32'd4;
    end
    m_fl = sw;
    if (sw) m_rc = RF;
    else if (m_rc > 0) m_rc--;
    if (sw) m_cur = 2'(g);
    else if (!mode && issue) m_cur = 2'((e_sel + 1) % NT);
    @(negedge clk);
  endtask

  task automatic drive(bit md, logic [NT-1:0] s_s, logic [NT-1:0] s_l, bit a);
    mode = md; ss = s_s; sl = s_l; adv = a; rv = '0;
  endtask

  initial begin
    #(TCLK * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    drive(0, '0, '0, 0);
    step("R1");
    // R3: rotation with all ready
    drive(0, '0, '0, 1);
    repeat (8) step("R3");
    // R2 R4: skip stalled threads
    drive(0, 4'b0010, 4'b0100, 1);
    repeat (6) step("R2 R4");
    // R5: everything stalled
    drive(0, 4'b0101, 4'b1010, 1);
    repeat (3) step("R5");
    // R6: no advance strobe, nothing moves
    drive(0, 4'b0000, 4'b0000, 0);
    repeat (2) step("R6");
    // R7: redirect the thread being issued in the same cycle
    drive(0, '0, '0, 1);
    rv = 4'b1 << m_cur;
    rp = {NT{32'hC0DE_0000}};
    step("R7");
    rv = '0;
    repeat (4) step("R7");
    // R8: switch mode holds thread, short stall does not switch
    drive(1, '0, '0, 1);
    repeat (4) step("R8");
    drive(1, 4'b1 << m_cur, '0, 1);
    repeat (3) step("R8");
    // R9: long stall on running thread
    drive(1, '0, 4'b1 << m_cur, 1);
    step("R9");
    // R10: refill window, with long stall on the new thread
    drive(1, '0, 4'b1 << m_cur, 1);
    repeat (RF) step("R10");
    drive(1, '0, '0, 1);
    repeat (2) step("R10");
    // R11: long stall with no other ready thread
    drive(1, ~(4'b1 << m_cur), 4'b1 << m_cur, 1);
    repeat (4) step("R11");
    drive(1, '0, '0, 1);
    repeat (2) step("R11");
    // random traffic
    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(0, 199) == 0) mode = ~mode;
      for (int t = 0; t < NT; t++) begin
        ss[t] = ($urandom_range(0, 5) == 0);
        sl[t] = ($urandom_range(0, mode ? 15 : 9) == 0);
        rv[t] = ($urandom_range(0, 9) == 0);
        rp[t*PW +: PW] = {$urandom_range(0, 65535), 16'h0} | (32'(t) << 2);
      end
      adv = ($urandom_range(0, 4) != 0);
      step("R2 R6 R7 R9 R10");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule